// File: doc/BRIEF.md
# Clock Idle Vote Mask

This block collects idle votes for a set of clock sources. Any number of requesters may forbid a clock from idling. Each vote against idling arrives as a one-cycle deny strobe, and each withdrawal of that vote arrives as a one-cycle allow strobe. For every clock the block keeps a saturating count of the votes still outstanding. It also keeps a permission bit that drops on the first vote and comes back only when the last vote is withdrawn.

Each clock's permission bit is placed into a shared mask word at a bit position that is given per clock. The power logic downstream reads this word to decide which clocks may be idled. A clock whose idle-control enable is low takes no part in the voting. Any one count can be read back through a select input, and a sticky flag per clock records an attempt to push its count past the maximum.

Top module: `civ_vote_mask`

## Requirements
- R1: After reset every count reads 0, every mask bit reads 1 and every overflow flag reads 0.
- R2: While a clock's idle-control enable is 0, its allow and deny strobes leave its count, its mask bit and its overflow flag unchanged.
- R3: A deny on an enabled clock raises its count by one on the next clock edge. When the count was 0 before the deny, the clock's mask bit reads 0 after that edge.
- R4: An allow on an enabled clock with a nonzero count lowers the count by one on the next edge.
- R5: When an allow brings a count from 1 to 0, the clock's mask bit reads 1 after that edge.
- R6: An allow on an enabled clock whose count is 0 changes neither the count nor the mask.
- R7: Clock i's permission appears at mask bit bit_pos_i[i*POS_W +: POS_W]. A mask bit that no clock maps to reads 1. A bit shared by several clocks reads 0 while any of those clocks has a nonzero count. The mapping is combinational.
- R8: A deny at count 2^CNT_W-1 (255 by default) leaves the count at that value and sets the clock's overflow flag. The flag stays set until reset.
- R9: An allow and a deny on the same clock in the same cycle cancel each other, and no state of that clock changes.
- R10: cnt_rd_o shows, combinationally, the count of the clock numbered by cnt_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| allow_i | input | NUM_CLK | Per-clock strobe that withdraws one vote against idling |
| deny_i | input | NUM_CLK | Per-clock strobe that adds one vote against idling |
| idle_ctl_en_i | input | NUM_CLK | Per-clock enable for idle voting |
| bit_pos_i | input | NUM_CLK*POS_W | Mask bit position of each clock, packed POS_W bits per clock |
| cnt_sel_i | input | SEL_W | Clock whose count is read back |
| cnt_rd_o | output | CNT_W | Count of the selected clock |
| idle_mask_o | output | MASK_W | Idle permission word, 1 = may idle |
| ovf_o | output | NUM_CLK | Sticky per-clock saturation flag |

## Verification
The bench goes after several corner cases. The first is an allow at count zero: a design that wraps there would show 255 and hold the mask bit low for good. The second is a deny at full count: a design that wraps would show 0 with the bit still cleared, and one that drops the sticky flag would lose the overflow record. It also checks that a simultaneous allow and deny leaves the count alone, since a design that gives one strobe priority would drift the count. Two clocks mapped onto one mask bit must keep that bit low until both counts reach zero, and a disabled clock must ignore its strobes. A long random stretch of strobes, enables and select values is then compared cycle by cycle against a behavioural model.

// File: rtl/civ_pkg.sv
package civ_pkg;

  // Next vote count: up/down by one, clamped to [0, cap], cancel when both.
  function automatic int unsigned vote_next(input int unsigned cur,
                                            input int unsigned cap,
                                            input logic up,
                                            input logic dn);
    int unsigned nxt;
    nxt = cur;
    if (up && !dn) begin
      if (cur != cap) nxt = cur + 1;
    end else if (dn && !up) begin
      if (cur != 0) nxt = cur - 1;
    end
    return nxt;
  endfunction

  // True when a deny would be refused because the count is already full.
  function automatic logic vote_saturates(input int unsigned cur,
                                          input int unsigned cap,
                                          input logic up,
                                          input logic dn);
    return up && !dn && (cur == cap);
  endfunction

endpackage

// File: rtl/civ_vote_ctr.sv
module civ_vote_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             allow,
  input  logic             deny,
  output logic [CNT_W-1:0] cnt_o,
  output logic             permit_o,
  output logic             ovf_o
);
  import civ_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam int unsigned      CAP_INT  = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             permit_q, ovf_q;

  // Named internal events
  logic req_deny, req_allow, ev_first_deny, ev_release, ev_sat, ev_cancel;

  assign req_deny      = ctl_en & deny & ~allow;
  assign req_allow     = ctl_en & allow & ~deny;
  assign ev_cancel     = ctl_en & allow & deny;
  assign ev_first_deny = req_deny & (cnt_q == '0);
  assign ev_release    = req_allow & (cnt_q == CNT_W'(1));
  assign ev_sat        = ctl_en & vote_saturates(int'(cnt_q), CAP_INT, deny, allow);

  always_comb begin
    cnt_d = cnt_q;
    if (ctl_en) cnt_d = CNT_W'(vote_next(int'(cnt_q), CAP_INT, deny, allow));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      permit_q <= 1'b1;
      ovf_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ev_first_deny)   permit_q <= 1'b0;
      else if (ev_release) permit_q <= 1'b1;
      if (ev_sat) ovf_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign permit_o = permit_q;
  assign ovf_o    = ovf_q;

  // R2: disabled clock holds its state
  p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> $stable(cnt_q) && $stable(permit_q) && $stable(ovf_q));
  // R3: deny below full count adds one
  p_deny_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_deny && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R4: allow above zero subtracts one
  p_allow_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_allow && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R5: permission register tracks an empty count
  p_permit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    permit_q == (cnt_q == '0));
  // R6: allow at zero leaves zero
  p_allow_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_allow && cnt_q == '0 |=> cnt_q == '0);
  // R8: saturation holds the count and raises the flag
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_deny && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX && ovf_q);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R9: simultaneous strobes cancel
  p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cancel |=> $stable(cnt_q) && $stable(permit_q));

endmodule

// File: rtl/civ_mask_map.sv
module civ_mask_map #(
  parameter int NUM_CLK = 4,
  parameter int MASK_W  = 16,
  parameter int POS_W   = 4
) (
  input  logic [NUM_CLK-1:0]       permit,
  input  logic [NUM_CLK*POS_W-1:0] pos,
  output logic [MASK_W-1:0]        mask
);

  // Bit position of clock i, as an integer
  function automatic int pos_of(input logic [NUM_CLK*POS_W-1:0] p, input int i);
    return int'(p[i*POS_W +: POS_W]);
  endfunction

  always_comb begin
    mask = '1;
    for (int i = 0; i < NUM_CLK; i++) begin
      for (int b = 0; b < MASK_W; b++) begin
        if (!permit[i] && pos_of(pos, i) == b) mask[b] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/civ_vote_mask.sv
module civ_vote_mask #(
  parameter int NUM_CLK = 4,
  parameter int CNT_W   = 8,
  parameter int MASK_W  = 16,
  parameter int POS_W   = (MASK_W > 1) ? $clog2(MASK_W) : 1,
  parameter int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CLK-1:0]       allow_i,
  input  logic [NUM_CLK-1:0]       deny_i,
  input  logic [NUM_CLK-1:0]       idle_ctl_en_i,
  input  logic [NUM_CLK*POS_W-1:0] bit_pos_i,
  input  logic [SEL_W-1:0]         cnt_sel_i,
  output logic [CNT_W-1:0]         cnt_rd_o,
  output logic [MASK_W-1:0]        idle_mask_o,
  output logic [NUM_CLK-1:0]       ovf_o
);

  logic [CNT_W-1:0]   cnt_arr [NUM_CLK];
  logic [NUM_CLK-1:0] permit;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
    civ_vote_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_en   (idle_ctl_en_i[g]),
      .allow    (allow_i[g]),
      .deny     (deny_i[g]),
      .cnt_o    (cnt_arr[g]),
      .permit_o (permit[g]),
      .ovf_o    (ovf_o[g])
    );

    // R7: a blocked clock forces its mapped mask bit low
    p_mask_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!permit[g] && int'(bit_pos_i[g*POS_W +: POS_W]) < MASK_W)
        |-> !idle_mask_o[bit_pos_i[g*POS_W +: POS_W]]);
  end

  civ_mask_map #(.NUM_CLK(NUM_CLK), .MASK_W(MASK_W), .POS_W(POS_W)) u_map (
    .permit (permit),
    .pos    (bit_pos_i),
    .mask   (idle_mask_o)
  );

  always_comb begin
    cnt_rd_o = '0;
    for (int i = 0; i < NUM_CLK; i++)
      if (int'(cnt_sel_i) == i) cnt_rd_o = cnt_arr[i];
  end

  // R1: all-idle word when every count is empty
  p_all_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (&permit) |-> (&idle_mask_o));

endmodule

// File: tb/sim_civ_vote_mask.sv
`timescale 1ns/1ps
module sim_civ_vote_mask;
  localparam int N = 4, CW = 8, MW = 16, PW = 4, SW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0]    allow = '0, deny = '0, en = '1;
  logic [N*PW-1:0] pos = '0;
  logic [SW-1:0]   sel = '0;
  logic [CW-1:0]   cnt_rd;
  logic [MW-1:0]   mask;
  logic [N-1:0]    ovf;

  int tests = 0, fails = 0;
  int m_cnt [N];
  bit m_ovf [N];

  always #2 clk = ~clk;

  civ_vote_mask #(.NUM_CLK(N), .CNT_W(CW), .MASK_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .allow_i(allow), .deny_i(deny),
    .idle_ctl_en_i(en), .bit_pos_i(pos), .cnt_sel_i(sel),
    .cnt_rd_o(cnt_rd), .idle_mask_o(mask), .ovf_o(ovf));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_mask();
    int m = 32'h0000_FFFF;
    for (int i = 0; i < N; i++)
      if (m_cnt[i] > 0) m &= ~(1 << int'(pos[i*PW +: PW]));
    return m;
  endfunction

  function automatic int exp_ovf();
    int v = 0;
    for (int i = 0; i < N; i++) if (m_ovf[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic compare(input string tag);
    chk(tag, "mask", int'(mask), exp_mask());
    chk("R10", "cnt_rd", int'(cnt_rd), m_cnt[int'(sel)]);
    chk(tag, "ovf", int'(ovf), exp_ovf());
  endtask

  // Called at a negedge: drive, compare combinational view, clock, update model
  task automatic step(input string tag, input logic [N-1:0] a, input logic [N-1:0] d);
    allow = a; deny = d; sel = sel + 1'b1;
    #1; compare(tag);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (en[i]) begin
        if (d[i] && !a[i]) begin
          if (m_cnt[i] == 255) m_ovf[i] = 1; else m_cnt[i]++;
        end else if (a[i] && !d[i] && m_cnt[i] > 0) m_cnt[i]--;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; end
    pos = {4'd12, 4'd7, 4'd3, 4'd0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state on every readback
    for (int k = 0; k < N; k++) step("R1", '0, '0);

    // R2: disabled clock 1 ignores deny and allow
    en = 4'b1101;
    step("R2", 4'b0000, 4'b0010);
    step("R2", 4'b0000, 4'b0010);
    step("R2", 4'b0010, 4'b0000);
    chk("R2", "mask bit3", int'(mask[3]), 1);
    en = 4'b1111;

    // R3 / R4 / R5 / R6 on clock 0
    step("R3", 4'b0000, 4'b0001);
    chk("R3", "mask bit0 after first deny", int'(mask[0]), 0);
    step("R3", 4'b0000, 4'b0001);
    step("R3", 4'b0000, 4'b0001);
    step("R4", 4'b0001, 4'b0000);
    step("R4", 4'b0001, 4'b0000);
    chk("R4", "mask bit0 still low", int'(mask[0]), 0);
    step("R5", 4'b0001, 4'b0000);
    chk("R5", "mask bit0 released", int'(mask[0]), 1);
    step("R6", 4'b0001, 4'b0000);
    step("R6", 4'b0001, 4'b0000);
    chk("R6", "mask bit0 at floor", int'(mask[0]), 1);

    // R9: simultaneous strobes cancel
    step("R9", 4'b0100, 4'b0100);
    step("R9", 4'b0000, 4'b0100);
    step("R9", 4'b0100, 4'b0100);
    chk("R9", "mask bit7", int'(mask[7]), 0);
    step("R9", 4'b0100, 4'b0000);

    // R7: remap and shared bit
    pos = {4'd15, 4'd0, 4'd9, 4'd0};
    step("R7", 4'b0000, 4'b0100);
    chk("R7", "shared bit0 low", int'(mask[0]), 0);
    step("R7", 4'b0000, 4'b0001);
    step("R7", 4'b0100, 4'b0000);
    chk("R7", "shared bit0 held by clock0", int'(mask[0]), 0);
    step("R7", 4'b0001, 4'b0000);
    chk("R7", "shared bit0 free", int'(mask[0]), 1);

    // R8: saturation of clock 3
    for (int k = 0; k < 256; k++) step("R8", 4'b0000, 4'b1000);
    sel = 2'd2;
    step("R8", 4'b0000, 4'b0000);
    chk("R8", "count at max", int'(cnt_rd), 255);
    chk("R8", "ovf set", int'(ovf[3]), 1);
    step("R8", 4'b1000, 4'b0000);
    step("R8", 4'b0000, 4'b0000);
    chk("R8", "ovf sticky", int'(ovf[3]), 1);

    // Random mix against the model (R3 R4 R9 R10)
    for (int k = 0; k < 2000; k++) begin
      en  = 4'($urandom_range(15, 0)) | 4'b0101;
      if (k % 97 == 0) pos = 16'($urandom);
      step("R3", 4'($urandom), 4'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule